// File: doc/BRIEF.md
# Buffered Mode and Counter Register Bank

This block gives a host bus access to two internal registers, a 32-bit mode register and an output counter, without ever touching them directly. Each internal register has a buffer register at its own address, which the host reads and writes with plain single-cycle accesses. A write of any data to a register's copy address moves the buffer into the internal register. A read of the copy address takes a snapshot of the internal register into the buffer. The host then reads the buffer at its own address. Copies can be issued at any time, so a running counter or a live mode word can be sampled or replaced without stopping the datapath.

The mode register also holds two sticky history flags for the datapath's 22-bit sample bus. Bit 22 is set by a positive overflow event and bit 23 by a negative overflow event. They are read together as a two-bit code: 00 means no overflow, 01 means positive only, 10 means negative only and 11 means both. Each flag stays set until the next copy-write to the mode register. The flags update no matter what the other mode bits hold. The counter advances on an external enable pulse and is loaded by a copy-write.

The addresses are: mode buffer 0xB0, mode copy 0xB4, counter buffer 0xB8 and counter copy 0xBC.

Top module: `shadow_bank`

## Requirements
- R1: After reset, mode_o, cnt_o, both buffers and rdata_o are all zero.
- R2: A write to 0xB0 (mode buffer) or 0xB8 (counter buffer) stores wdata_i in that buffer. A read with rd_en_i high returns that buffer on rdata_o in the same cycle. Neither access changes mode_o or cnt_o.
- R3: A write to 0xB4 loads mode_o from the mode buffer on the next clock edge. Bits 23:22 are cleared instead of being loaded.
- R4: A read of 0xB4 (with wr_en_i low) copies the mode register as it stood before that edge, flags included, into the mode buffer. mode_o is not changed.
- R5: A high ovf_pos_i sets mode_o[22] on the next edge. The flag then stays set until a copy-write to 0xB4, whatever the other mode bits hold.
- R6: A high ovf_neg_i sets mode_o[23] on the next edge. The flag then stays set until a copy-write to 0xB4.
- R7: When an overflow event and a copy-write to 0xB4 fall in the same cycle, the flag of that event is set after the edge.
- R8: cnt_o increases by one on each edge where cnt_en_i is high, and wraps from all ones to zero.
- R9: A write to 0xBC loads cnt_o from the counter buffer. The load takes precedence over a cnt_en_i pulse in the same cycle.
- R10: A read of 0xBC (with wr_en_i low) copies the counter value from before that edge into the counter buffer. A same-cycle cnt_en_i still advances cnt_o.
- R11: Reads of 0xB4, 0xBC and unmapped addresses return zero. Writes to unmapped addresses change no register.
- R12: When wr_en_i and rd_en_i are both high, only the write takes effect and no snapshot is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 8 | Host byte address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, combinational |
| ovf_pos_i | input | 1 | Positive overflow event on the sample bus |
| ovf_neg_i | input | 1 | Negative overflow event on the sample bus |
| cnt_en_i | input | 1 | Counter advance pulse |
| mode_o | output | 32 | Internal mode register, flags in bits 23:22 |
| cnt_o | output | 32 | Internal output counter |

## Verification
The collisions that matter are an overflow event landing in the same cycle as a copy-write that clears the flags, and a counter enable landing in the same cycle as a counter copy-write or copy-read. The bench drives each pair together on one edge. A reference model, computed from the requirements, decides the outcome: the flag stays set, the load wins over the increment, and the snapshot holds the value from before the edge. The model is compared with mode_o, cnt_o and rdata_o on every clock.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

  typedef struct packed {
    logic mode_buf_wr;
    logic mode_copy_wr;
    logic mode_copy_rd;
    logic cnt_buf_wr;
    logic cnt_copy_wr;
    logic cnt_copy_rd;
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_NONE     = 2'd0,
    SEL_MODE_BUF = 2'd1,
    SEL_CNT_BUF  = 2'd2
  } rd_sel_e;

endpackage

// File: rtl/sb_decode.sv
module sb_decode
  import shadow_bank_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] MODE_BUF_ADDR  = 8'hB0,
  parameter logic [ADDR_W-1:0] MODE_COPY_ADDR = 8'hB4,
  parameter logic [ADDR_W-1:0] CNT_BUF_ADDR   = 8'hB8,
  parameter logic [ADDR_W-1:0] CNT_COPY_ADDR  = 8'hBC
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           stb_o,
  output rd_sel_e           sel_o
);

  logic rd_only;
  assign rd_only = rd_en_i & ~wr_en_i;  // write wins on a combined access

  always_comb begin
    stb_o.mode_buf_wr  = wr_en_i && (addr_i == MODE_BUF_ADDR);
    stb_o.mode_copy_wr = wr_en_i && (addr_i == MODE_COPY_ADDR);
    stb_o.mode_copy_rd = rd_only && (addr_i == MODE_COPY_ADDR);
    stb_o.cnt_buf_wr   = wr_en_i && (addr_i == CNT_BUF_ADDR);
    stb_o.cnt_copy_wr  = wr_en_i && (addr_i == CNT_COPY_ADDR);
    stb_o.cnt_copy_rd  = rd_only && (addr_i == CNT_COPY_ADDR);
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (rd_en_i) begin
      if (addr_i == MODE_BUF_ADDR)     sel_o = SEL_MODE_BUF;
      else if (addr_i == CNT_BUF_ADDR) sel_o = SEL_CNT_BUF;
    end
  end

endmodule

// File: rtl/sb_mode_reg.sv
module sb_mode_reg #(
  parameter int DATA_W  = 32,
  parameter int POS_BIT = 22,
  parameter int NEG_BIT = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_wr_i,
  input  logic              copy_wr_i,
  input  logic              copy_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        ovf_i,    // [0] positive, [1] negative
  output logic [DATA_W-1:0] buf_o,
  output logic [DATA_W-1:0] reg_o
);

  localparam int NFLAG = 2;
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << POS_BIT) | (DATA_W'(1) << NEG_BIT);

  logic [DATA_W-1:0] body_q;
  logic [DATA_W-1:0] buf_q;
  logic [NFLAG-1:0]  flag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        body_q <= '0;
    else if (copy_wr_i) body_q <= buf_q & ~FLAG_MASK;
  end

  // sticky flags: a new event beats the clear from a copy-write
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        f_q <= 1'b0;
      else if (ovf_i[g])  f_q <= 1'b1;
      else if (copy_wr_i) f_q <= 1'b0;
    end
    assign flag_w[g] = f_q;
  end

  always_comb begin
    reg_o          = body_q;
    reg_o[POS_BIT] = flag_w[0];
    reg_o[NEG_BIT] = flag_w[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        buf_q <= '0;
    else if (buf_wr_i)  buf_q <= wdata_i;
    else if (copy_rd_i) buf_q <= reg_o;
  end

  assign buf_o = buf_q;

endmodule

// File: rtl/sb_counter.sv
module sb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_wr_i,
  input  logic             copy_wr_i,
  input  logic             copy_rd_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] buf_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (copy_wr_i) cnt_q <= buf_q;
    else if (inc_i)     cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        buf_q <= '0;
    else if (buf_wr_i)  buf_q <= wdata_i;
    else if (copy_rd_i) buf_q <= cnt_q;
  end

  assign buf_o = buf_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter int                DATA_W         = 32,
  parameter int                CNT_W          = 32,
  parameter int                POS_BIT        = 22,
  parameter int                NEG_BIT        = 23,
  parameter logic [ADDR_W-1:0] MODE_BUF_ADDR  = 8'hB0,
  parameter logic [ADDR_W-1:0] MODE_COPY_ADDR = 8'hB4,
  parameter logic [ADDR_W-1:0] CNT_BUF_ADDR   = 8'hB8,
  parameter logic [ADDR_W-1:0] CNT_COPY_ADDR  = 8'hBC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ovf_pos_i,
  input  logic              ovf_neg_i,
  input  logic              cnt_en_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [CNT_W-1:0]  cnt_o
);

  strobe_t           stb;
  rd_sel_e           sel;
  logic [DATA_W-1:0] mode_buf;
  logic [CNT_W-1:0]  cnt_buf;

  sb_decode #(
    .ADDR_W(ADDR_W), .MODE_BUF_ADDR(MODE_BUF_ADDR), .MODE_COPY_ADDR(MODE_COPY_ADDR),
    .CNT_BUF_ADDR(CNT_BUF_ADDR), .CNT_COPY_ADDR(CNT_COPY_ADDR)
  ) u_decode (
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .stb_o(stb), .sel_o(sel)
  );

  sb_mode_reg #(.DATA_W(DATA_W), .POS_BIT(POS_BIT), .NEG_BIT(NEG_BIT)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .buf_wr_i(stb.mode_buf_wr), .copy_wr_i(stb.mode_copy_wr), .copy_rd_i(stb.mode_copy_rd),
    .wdata_i(wdata_i), .ovf_i({ovf_neg_i, ovf_pos_i}),
    .buf_o(mode_buf), .reg_o(mode_o)
  );

  sb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .buf_wr_i(stb.cnt_buf_wr), .copy_wr_i(stb.cnt_copy_wr), .copy_rd_i(stb.cnt_copy_rd),
    .inc_i(cnt_en_i), .wdata_i(wdata_i[CNT_W-1:0]),
    .buf_o(cnt_buf), .cnt_o(cnt_o)
  );

  always_comb begin
    unique case (sel)
      SEL_MODE_BUF: rdata_o = mode_buf;
      SEL_CNT_BUF:  rdata_o = DATA_W'(cnt_buf);
      default:      rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int                ADDR_W         = 8,
  parameter int                DATA_W         = 32,
  parameter int                CNT_W          = 32,
  parameter int                POS_BIT        = 22,
  parameter int                NEG_BIT        = 23,
  parameter logic [ADDR_W-1:0] MODE_COPY_ADDR = 8'hB4,
  parameter logic [ADDR_W-1:0] CNT_COPY_ADDR  = 8'hBC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ovf_pos_i,
  input logic              ovf_neg_i,
  input logic              cnt_en_i,
  input logic [DATA_W-1:0] mode_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [DATA_W-1:0] mode_buf,
  input logic [CNT_W-1:0]  cnt_buf
);

  localparam logic [DATA_W-1:0] FLAGS =
    (DATA_W'(1) << POS_BIT) | (DATA_W'(1) << NEG_BIT);

  logic m_cw, m_cr, c_cw, c_cr;
  assign m_cw = wr_en_i && (addr_i == MODE_COPY_ADDR);
  assign m_cr = rd_en_i && !wr_en_i && (addr_i == MODE_COPY_ADDR);
  assign c_cw = wr_en_i && (addr_i == CNT_COPY_ADDR);
  assign c_cr = rd_en_i && !wr_en_i && (addr_i == CNT_COPY_ADDR);

  assert_copy_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cw && !ovf_pos_i && !ovf_neg_i) |=> (mode_o == ($past(mode_buf) & ~FLAGS)));

  assert_snapshot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_cr |=> (mode_buf == $past(mode_o)));

  assert_pos_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pos_i |=> mode_o[POS_BIT]);

  assert_pos_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[POS_BIT] && !m_cw) |=> mode_o[POS_BIT]);

  assert_neg_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_neg_i |=> mode_o[NEG_BIT]);

  assert_neg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[NEG_BIT] && !m_cw) |=> mode_o[NEG_BIT]);

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cw && ovf_neg_i) |=> mode_o[NEG_BIT]);

  assert_cnt_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !c_cw) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  assert_cnt_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_cw |=> (cnt_o == $past(cnt_buf)));

  assert_cnt_snap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_cr |=> (cnt_buf == $past(cnt_o)));

endmodule

bind shadow_bank shadow_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .POS_BIT(POS_BIT), .NEG_BIT(NEG_BIT),
  .MODE_COPY_ADDR(MODE_COPY_ADDR), .CNT_COPY_ADDR(CNT_COPY_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .ovf_pos_i(ovf_pos_i), .ovf_neg_i(ovf_neg_i), .cnt_en_i(cnt_en_i),
  .mode_o(mode_o), .cnt_o(cnt_o), .mode_buf(mode_buf), .cnt_buf(cnt_buf)
);

// File: tb/shadow_bank_tb.sv
`timescale 1ns/1ps
module shadow_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ovf_pos = 1'b0, ovf_neg = 1'b0, cnt_en = 1'b0;
  logic [31:0] rdata, mode, cnt;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg = '0, m_buf = '0, c_reg = '0, c_buf = '0;
  localparam logic [31:0] FLAGS = 32'h00C0_0000;

  always #4 clk = ~clk;

  shadow_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ovf_pos_i(ovf_pos), .ovf_neg_i(ovf_neg),
    .cnt_en_i(cnt_en), .mode_o(mode), .cnt_o(cnt)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and compares against the model
  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [31:0] d,
                      input logic op, input logic on, input logic ce);
    logic [31:0] er, nm, nmb, nc, ncb;
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    ovf_pos = op; ovf_neg = on; cnt_en = ce;
    #1;
    er = '0;
    if (rd && a == 8'hB0) er = m_buf;
    if (rd && a == 8'hB8) er = c_buf;
    chk(tag, "rdata", rdata, er);
    nm = m_reg; nmb = m_buf; nc = c_reg; ncb = c_buf;
    if (wr) begin
      if (a == 8'hB0) nmb = d;
      if (a == 8'hB4) nm = m_buf & ~FLAGS;
      if (a == 8'hB8) ncb = d;
      if (a == 8'hBC) nc = c_buf;
    end else if (rd) begin
      if (a == 8'hB4) nmb = m_reg;
      if (a == 8'hBC) ncb = c_reg;
    end
    if (ce && !(wr && a == 8'hBC)) nc = c_reg + 32'd1;
    if (op) nm[22] = 1'b1;
    if (on) nm[23] = 1'b1;
    @(posedge clk);
    m_reg = nm; m_buf = nmb; c_reg = nc; c_buf = ncb;
    @(negedge clk);
    chk(tag, "mode", mode, m_reg);
    chk(tag, "cnt", cnt, c_reg);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, 32'h0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "mode", mode, 32'h0);
    chk("R1", "cnt", cnt, 32'h0);
    step("R1", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    step("R1", 0, 1, 8'hB8, 32'h0, 0, 0, 0);
    // R2 buffers
    step("R2", 1, 0, 8'hB0, 32'hFFFF_FFFF, 0, 0, 0);
    step("R2", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    step("R2", 1, 0, 8'hB8, 32'hA5A5_0F0F, 0, 0, 0);
    step("R2", 0, 1, 8'hB8, 32'h0, 0, 0, 0);
    // R3 copy-write clears flag bits
    step("R3", 1, 0, 8'hB4, 32'h1234_5678, 0, 0, 0);
    // R5 positive flag, sticky with other bits set
    step("R5", 0, 0, 8'h00, 32'h0, 1, 0, 0);
    idle("R5", 3);
    // R4 snapshot, with a neg event on the same edge (snapshot predates it)
    step("R4", 0, 1, 8'hB4, 32'h0, 0, 1, 0);
    step("R4", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    // R6 negative flag sticky, snapshot shows both
    idle("R6", 2);
    step("R6", 0, 1, 8'hB4, 32'h0, 0, 0, 0);
    step("R6", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    // R7 event wins over clear
    step("R7", 1, 0, 8'hB0, 32'h0000_00AA, 0, 0, 0);
    step("R7", 1, 0, 8'hB4, 32'h0, 0, 0, 0);
    step("R7", 1, 0, 8'hB4, 32'h0, 0, 1, 0);
    step("R7", 1, 0, 8'hB4, 32'h0, 1, 0, 0);
    step("R7", 1, 0, 8'hB4, 32'h0, 0, 0, 0);
    // R8 counting
    for (int i = 0; i < 5; i++) step("R8", 0, 0, 8'h00, 32'h0, 0, 0, 1);
    // R9 load beats increment
    step("R9", 1, 0, 8'hB8, 32'hFFFF_FFFE, 0, 0, 1);
    step("R9", 1, 0, 8'hBC, 32'h0, 0, 0, 1);
    step("R8", 0, 0, 8'h00, 32'h0, 0, 0, 1);
    step("R8", 0, 0, 8'h00, 32'h0, 0, 0, 1);
    step("R8", 0, 0, 8'h00, 32'h0, 0, 0, 1);
    // R10 snapshot predates same-cycle increment
    step("R10", 0, 1, 8'hBC, 32'h0, 0, 0, 1);
    step("R10", 0, 1, 8'hB8, 32'h0, 0, 0, 0);
    // R11 copy and unmapped reads, unmapped write
    step("R11", 1, 0, 8'h40, 32'hDEAD_BEEF, 0, 0, 0);
    step("R11", 0, 1, 8'h40, 32'h0, 0, 0, 0);
    step("R11", 0, 1, 8'hB4, 32'h0, 0, 0, 0);
    step("R11", 0, 1, 8'hBC, 32'h0, 0, 0, 0);
    step("R11", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    step("R11", 0, 1, 8'hB8, 32'h0, 0, 0, 0);
    // R12 combined access: write only
    step("R12", 1, 0, 8'hB0, 32'h0F0F_F0F0, 1, 0, 0);
    step("R12", 1, 1, 8'hB4, 32'h0, 0, 0, 0);
    step("R12", 0, 1, 8'hB0, 32'h0, 0, 0, 0);
    step("R12", 1, 0, 8'hB8, 32'h0000_1111, 0, 0, 0);
    step("R12", 1, 1, 8'hBC, 32'h0, 0, 0, 1);
    step("R12", 0, 1, 8'hB8, 32'h0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL all watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule